// File: doc/BRIEF.md
# Clear-on-read event status register

This block gathers asynchronous condition signals from the analog side of a dual card-reader front end and latches them into one 8-bit status word. Two short-circuit detectors, an undervoltage supervisor with its alarm pulse and an external reset line, two card-presence switches, an auxiliary interrupt line and an over-temperature flag all feed it. Every input passes through a two-flop synchronizer first. Each status bit then follows its own set and clear rule. Most bits pull an active-low interrupt line while they are set.

Software reads the word through a simple read port: a strobe, an address and 8-bit data. A read that hits the status address returns the bits as they were before the read and applies each bit's clear rule in the same cycle. Some bits clear on any read. Some clear only if their condition has gone away. The supervisor bit clears only when no alarm pulse is present. A spacing counter flags any read that follows the previous one too closely.

Top module: `evt_status_reg`

## Requirements
- R1: Bit positions are: 7 reserved (reads 0), 6 fault B, 5 fault A, 4 supervisor, 3 presence B, 2 presence A, 1 auxiliary, 0 thermal. A read hit is `rd_en_i` high while `rd_addr_i` equals parameter `STAT_ADDR`. The status word appears on `rd_data_o` one cycle after the hit and holds there until the next hit.
- R2: A synchronous reset loads status 0x10 (only the supervisor bit set). It also clears `rd_data_o` to 0x00, drives `irq_n_o` low and clears `rd_too_soon_o`.
- R3: A fault bit is 1 while its short-circuit input is active. A read clears it only if that input is inactive at the read.
- R4: The supervisor bit sets while the undervoltage input or the external reset input is active. A read clears it only if the alarm-pulse input is inactive at the read.
- R5: A presence bit sets on either edge of its presence input. Any read clears it.
- R6: The auxiliary bit sets on either edge of its input and stays set through further edges until a read. It never drives `irq_n_o`.
- R7: The thermal bit is 1 while the over-temperature input is active. A read clears it only if that input is inactive at the read.
- R8: `irq_n_o` is 0 exactly when any of bits 6, 5, 4, 3, 2 or 0 is 1.
- R9: Each input is synchronized by two flops. A change driven between clock edges shows in the status, and in `irq_n_o`, after the third rising edge. Edges are ignored during the first three cycles after reset.
- R10: If a set condition and a clearing read meet in the same cycle, the bit stays 1. The read returns the value from before that cycle.
- R11: Two read hits must be at least `MIN_GAP` cycles apart. A hit that comes fewer than `MIN_GAP` cycles after the previous one raises `rd_too_soon_o` for the single cycle after that hit. The read itself still takes effect.
- R12: A strobe at any other address leaves both the status bits and `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address |
| flt_a_i | input | 1 | Short-circuit detect, interface A |
| flt_b_i | input | 1 | Short-circuit detect, interface B |
| uv_alarm_i | input | 1 | Undervoltage alarm |
| ext_rst_i | input | 1 | External reset event |
| alarm_pulse_i | input | 1 | Supervisor alarm pulse in progress |
| pres_a_i | input | 1 | Card presence switch A |
| pres_b_i | input | 1 | Card presence switch B |
| aux_i | input | 1 | Auxiliary interrupt line |
| hot_i | input | 1 | Over-temperature flag |
| rd_data_o | output | 8 | Status word captured by the last read hit |
| irq_n_o | output | 1 | Active-low interrupt |
| rd_too_soon_o | output | 1 | One-cycle pulse for a read that violates the spacing |

## Verification
The assertions assume that the reset is held for at least one edge before the first check. They also assume that condition inputs are plain levels, which the synchronizers settle into the status pipeline. The properties that relate a read to a bit's persistence look at the synchronized input in the cycle of the read, not at the raw pin. The stimulus therefore changes inputs only on falling edges and holds them for several cycles before it reads. The one exception is the same-cycle set-and-clear case, where an edge is timed deliberately to reach the latch on the read cycle. Reads are kept `MIN_GAP` apart, except in the spacing tests that break that rule on purpose.

// File: rtl/evt_stat_pkg.sv
package evt_stat_pkg;

    localparam int STAT_W      = 8;
    localparam int SYNC_STAGES = 2;

    // Bit order is the software-visible layout.
    typedef struct packed {
        logic rsvd;
        logic flt_b;
        logic flt_a;
        logic sup;
        logic pres_b;
        logic pres_a;
        logic aux;
        logic hot;
    } stat_t;

    typedef struct packed {
        logic flt_b;
        logic flt_a;
        logic uv;
        logic ext_rst;
        logic pulse;
        logic pres_b;
        logic pres_a;
        logic aux;
        logic hot;
    } cond_t;

    localparam int COND_W = $bits(cond_t);

    typedef enum logic [1:0] {
        CLR_ANY_READ,
        CLR_IF_GONE,
        CLR_OUT_OF_PULSE
    } clr_mode_e;

    localparam stat_t STAT_RESET = '{rsvd: 1'b0, flt_b: 1'b0, flt_a: 1'b0, sup: 1'b1,
                                     pres_b: 1'b0, pres_a: 1'b0, aux: 1'b0, hot: 1'b0};

    function automatic clr_mode_e cell_mode(input int idx);
        case (idx)
            6, 5, 0: return CLR_IF_GONE;
            4:       return CLR_OUT_OF_PULSE;
            default: return CLR_ANY_READ;
        endcase
    endfunction

    function automatic logic irq_active(input stat_t s);
        return s.flt_b | s.flt_a | s.sup | s.pres_b | s.pres_a | s.hot;
    endfunction

endpackage

// File: rtl/evt_sync.sv
module evt_sync
    import evt_stat_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] chg_o
);
    localparam int WARM   = SYNC_STAGES + 1;
    localparam int WARM_W = $clog2(WARM + 1);

    logic [SYNC_STAGES-1:0][W-1:0] pipe;
    logic [W-1:0]                  prev;
    logic [WARM_W-1:0]             warm_cnt;
    logic                          warm;

    assign warm = (warm_cnt == WARM_W'(WARM));

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe     <= '0;
            prev     <= '0;
            warm_cnt <= '0;
        end else begin
            pipe[0] <= raw_i;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
            prev <= pipe[SYNC_STAGES-1];
            if (!warm) begin
                warm_cnt <= warm_cnt + 1'b1;
            end
        end
    end

    assign lvl_o = pipe[SYNC_STAGES-1];
    assign chg_o = warm ? (pipe[SYNC_STAGES-1] ^ prev) : '0;

    // R9: no edge is reported before the pipeline has filled
    a_r9_no_early_edge: assert property (@(posedge clk) disable iff (rst)
        !warm |-> (chg_o == '0));

endmodule

// File: rtl/evt_cell.sv
module evt_cell
    import evt_stat_pkg::*;
#(
    parameter clr_mode_e MODE    = CLR_ANY_READ,
    parameter logic      RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic cond_i,
    input  logic pulse_i,
    input  logic rd_i,
    output logic q_o
);
    logic clr;

    always_comb begin
        case (MODE)
            CLR_IF_GONE:      clr = rd_i && !cond_i;
            CLR_OUT_OF_PULSE: clr = rd_i && !pulse_i;
            default:          clr = rd_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= RST_VAL;
        end else begin
            q_o <= set_i | (q_o & ~clr);
        end
    end

    // R10: a set event always wins over a clearing read
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);

    // R5: without a read a set bit never drops
    a_r5_hold_no_read: assert property (@(posedge clk) disable iff (rst)
        (q_o && !rd_i) |=> q_o);

endmodule

// File: rtl/rd_gap_check.sv
module rd_gap_check #(
    parameter int MIN_GAP = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic hit_i,
    output logic too_soon_o
);
    localparam int            CW     = $clog2(MIN_GAP + 1) + 1;
    localparam logic [CW-1:0] LIM    = CW'(MIN_GAP);
    localparam logic [CW-1:0] LIM_M1 = CW'(MIN_GAP - 1);

    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            since      <= LIM;
            too_soon_o <= 1'b0;
        end else begin
            too_soon_o <= hit_i && (since < LIM_M1);
            if (hit_i) begin
                since <= '0;
            end else if (since < LIM) begin
                since <= since + 1'b1;
            end
        end
    end

    // R11: a read after a full idle window never flags
    a_r11_spaced_ok: assert property (@(posedge clk) disable iff (rst)
        (hit_i && since == LIM) |=> !too_soon_o);

    // R11: the flag is only ever a response to a read
    a_r11_flag_needs_read: assert property (@(posedge clk) disable iff (rst)
        !hit_i |=> !too_soon_o);

    if (MIN_GAP > 1) begin : g_b2b
        a_r11_back_to_back: assert property (@(posedge clk) disable iff (rst)
            hit_i ##1 hit_i |=> too_soon_o);
    end

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
    import evt_stat_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(10),
    parameter int              MIN_GAP   = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              flt_a_i,
    input  logic              flt_b_i,
    input  logic              uv_alarm_i,
    input  logic              ext_rst_i,
    input  logic              alarm_pulse_i,
    input  logic              pres_a_i,
    input  logic              pres_b_i,
    input  logic              aux_i,
    input  logic              hot_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              irq_n_o,
    output logic              rd_too_soon_o
);
    cond_t              raw, lvl, chg;
    logic [COND_W-1:0]  lvl_v, chg_v;
    stat_t              set_v, cond_v, stat_q;
    logic [STAT_W-1:0]  stat_bits;
    logic               rd_hit;

    always_comb begin
        raw = '{flt_b: flt_b_i, flt_a: flt_a_i, uv: uv_alarm_i, ext_rst: ext_rst_i,
                pulse: alarm_pulse_i, pres_b: pres_b_i, pres_a: pres_a_i,
                aux: aux_i, hot: hot_i};
    end

    evt_sync #(.W(COND_W)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_i (raw),
        .lvl_o (lvl_v),
        .chg_o (chg_v)
    );

    assign lvl = cond_t'(lvl_v);
    assign chg = cond_t'(chg_v);

    always_comb begin
        set_v        = '0;
        set_v.flt_b  = lvl.flt_b;
        set_v.flt_a  = lvl.flt_a;
        set_v.sup    = lvl.uv | lvl.ext_rst;
        set_v.pres_b = chg.pres_b;
        set_v.pres_a = chg.pres_a;
        set_v.aux    = chg.aux;
        set_v.hot    = lvl.hot;

        cond_v       = '0;
        cond_v.flt_b = lvl.flt_b;
        cond_v.flt_a = lvl.flt_a;
        cond_v.hot   = lvl.hot;
    end

    assign rd_hit = rd_en_i && (rd_addr_i == STAT_ADDR);

    for (genvar i = 0; i < STAT_W - 1; i++) begin : g_cell
        evt_cell #(
            .MODE    (cell_mode(i)),
            .RST_VAL (STAT_RESET[i])
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_i   (set_v[i]),
            .cond_i  (cond_v[i]),
            .pulse_i (lvl.pulse),
            .rd_i    (rd_hit),
            .q_o     (stat_bits[i])
        );
    end
    assign stat_bits[STAT_W-1] = 1'b0;
    assign stat_q = stat_t'(stat_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_o <= '0;
        end else if (rd_hit) begin
            rd_data_o <= stat_q;
        end
    end

    assign irq_n_o = !irq_active(stat_q);

    rd_gap_check #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk        (clk),
        .rst        (rst),
        .hit_i      (rd_hit),
        .too_soon_o (rd_too_soon_o)
    );

    // R1: read data is the pre-clear snapshot
    a_r1_snapshot: assert property (@(posedge clk) disable iff (rst)
        rd_hit |=> (rd_data_o == $past(stat_q)));

    // R12: a miss leaves the read data alone
    a_r12_miss_stable: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> $stable(rd_data_o));

    // R3: a fault still present at the read survives it
    a_r3_fault_persist: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && lvl.flt_a) |=> stat_q.flt_a);

    // R4: a read during the alarm pulse keeps the supervisor bit
    a_r4_sup_in_pulse: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && lvl.pulse && stat_q.sup) |=> stat_q.sup);

    // R6: the auxiliary bit alone never pulls the interrupt
    a_r6_aux_quiet: assert property (@(posedge clk) disable iff (rst)
        (stat_q == stat_t'(8'h02)) |-> irq_n_o);

    // R7: thermal bit survives a read while still hot
    a_r7_hot_persist: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && lvl.hot) |=> stat_q.hot);

endmodule

// File: tb/evt_status_reg_test.sv
`timescale 1ns/1ps
module evt_status_reg_test;
    import evt_stat_pkg::*;

    localparam int         GAP  = 16;
    localparam logic [3:0] ADDR = 4'hA;
    localparam int         NV   = 23;

    // {inputs flt_b,flt_a,uv,ext_rst,pulse,pres_b,pres_a,aux,hot ; data ; irq_n before read}
    localparam logic [17:0] VEC [NV] = '{
        {9'b000000000, 8'h00, 1'b1},  // idle
        {9'b010000000, 8'h20, 1'b0},  // R3 fault A set
        {9'b010000000, 8'h20, 1'b0},  // R3 survives read while active
        {9'b000000000, 8'h20, 1'b0},  // R3 held until next read
        {9'b000000000, 8'h00, 1'b1},
        {9'b000001000, 8'h08, 1'b0},  // R5 presence B rise
        {9'b000001000, 8'h00, 1'b1},  // R5 steady level no set
        {9'b000000000, 8'h08, 1'b0},  // R5 presence B fall
        {9'b000000010, 8'h02, 1'b1},  // R6 aux rise, no irq
        {9'b000000000, 8'h02, 1'b1},  // R6 aux fall
        {9'b000000001, 8'h01, 1'b0},  // R7 thermal
        {9'b000000000, 8'h01, 1'b0},  // R7 survived hot read
        {9'b000000000, 8'h00, 1'b1},
        {9'b001010000, 8'h10, 1'b0},  // R4 undervoltage with pulse
        {9'b000010000, 8'h10, 1'b0},  // R4 read in pulse keeps
        {9'b000000000, 8'h10, 1'b0},  // R4 read outside pulse clears
        {9'b000000000, 8'h00, 1'b1},
        {9'b000100000, 8'h10, 1'b0},  // R4 external reset
        {9'b000000000, 8'h10, 1'b0},
        {9'b000000000, 8'h00, 1'b1},
        {9'b100000100, 8'h44, 1'b0},  // R3 fault B plus R5 presence A
        {9'b000000000, 8'h44, 1'b0},
        {9'b000000000, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rd_en = 1'b0;
    logic [3:0] rd_addr = '0;
    cond_t drv = '0;
    logic [7:0] rd_data;
    logic irq_n, too_soon;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_status_reg #(.ADDR_W(4), .STAT_ADDR(ADDR), .MIN_GAP(GAP)) uut (
        .clk           (clk),
        .rst           (rst),
        .rd_en_i       (rd_en),
        .rd_addr_i     (rd_addr),
        .flt_a_i       (drv.flt_a),
        .flt_b_i       (drv.flt_b),
        .uv_alarm_i    (drv.uv),
        .ext_rst_i     (drv.ext_rst),
        .alarm_pulse_i (drv.pulse),
        .pres_a_i      (drv.pres_a),
        .pres_b_i      (drv.pres_b),
        .aux_i         (drv.aux),
        .hot_i         (drv.hot),
        .rd_data_o     (rd_data),
        .irq_n_o       (irq_n),
        .rd_too_soon_o (too_soon)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [3:0] a);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        #1;
    endtask

    task automatic idle_gap();
        repeat (GAP) @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R2 data", rd_data, 8'h00);
        chk("R2 irq", {7'b0, irq_n}, 8'h00);
        chk("R2 flag", {7'b0, too_soon}, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        settle();
        do_read(ADDR);
        chk("R2 status", rd_data, 8'h10);
        chk("R11 first read", {7'b0, too_soon}, 8'h00);
        idle_gap();

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drv = cond_t'(VEC[i][17:9]);
            settle();
            chk("R8 irq", {7'b0, irq_n}, {7'b0, VEC[i][0]});
            do_read(ADDR);
            chk("R1 data", rd_data, VEC[i][8:1]);
            idle_gap();
        end

        // R9: latency of three edges
        @(negedge clk);
        drv.hot = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R9 before", {7'b0, irq_n}, 8'h01);
        @(posedge clk);
        #1;
        chk("R9 after", {7'b0, irq_n}, 8'h00);
        @(negedge clk);
        drv.hot = 1'b0;
        settle();
        do_read(ADDR);
        chk("R7 cleanup", rd_data, 8'h01);
        idle_gap();

        // R10: presence edge reaches the latch on the read cycle
        @(negedge clk);
        drv.pres_a = 1'b1;
        repeat (2) @(posedge clk);
        do_read(ADDR);
        chk("R10 pre-clear", rd_data, 8'h00);
        idle_gap();
        do_read(ADDR);
        chk("R10 set kept", rd_data, 8'h04);
        idle_gap();

        // R12: wrong address ignored
        @(negedge clk);
        drv.pres_a = 1'b0;
        settle();
        do_read(ADDR ^ 4'h1);
        chk("R12 data held", rd_data, 8'h04);
        chk("R12 irq held", {7'b0, irq_n}, 8'h00);
        idle_gap();
        do_read(ADDR);
        chk("R12 bit kept", rd_data, 8'h04);
        chk("R12 cleared irq", {7'b0, irq_n}, 8'h01);
        idle_gap();

        // R11: spacing
        do_read(ADDR);
        repeat (GAP - 1) @(posedge clk);
        do_read(ADDR);
        chk("R11 exact gap", {7'b0, too_soon}, 8'h00);
        repeat (GAP - 2) @(posedge clk);
        do_read(ADDR);
        chk("R11 one short", {7'b0, too_soon}, 8'h01);
        do_read(ADDR);
        chk("R11 back to back", {7'b0, too_soon}, 8'h01);
        @(posedge clk);
        #1;
        chk("R11 one cycle", {7'b0, too_soon}, 8'h00);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule